// File: doc/BRIEF.md
# Programmable 16x Baud Divisor Generator

This block turns a system clock, or a slower external baud clock, into a one-cycle tick at sixteen times the serial bit rate. The host sets the rate through a 16-bit divisor, which is kept as two byte-wide halves with separate write strobes. The divisor is the input step rate divided by sixteen times the wanted baud rate. It can be any value from 1 to 65535, and zero stops the generator. Receivers and transmitters elsewhere in the chip use `tick_o` as their oversampling enable. `baud_o` is a square wave at the tick rate, for pins or for observation.

Each step input decrements a down-counter. When the counter passes zero it reloads from the divisor and emits a tick. A step is either every cycle in which `baud_en_i` is high, or every synchronized rising edge of `ext_baud_i` while `baud_en_i` is high. A write to either divisor byte reloads the counter on the next clock edge, so a new rate takes effect at once and never waits for a stale count to run out.

Top module: `baud_divgen`

## Requirements
- R1: While reset is held and after its release, `tick_o` and `baud_o` are low. The divisor resets to zero, so no tick appears until the host writes a divisor.
- R2: A write with `wr_lo_i` high stores `wdata_i` into divisor bits 7:0. A write with `wr_hi_i` high stores it into bits 15:8. With steps on every cycle, ticks then repeat every divisor cycles.
- R3: A write to either byte reloads the counter on the next edge, whatever the old count was. With steps on every cycle, the first tick is seen divisor+1 cycles after the write edge.
- R4: The counter changes only on step cycles or on a reload. With `baud_en_i` low, `tick_o` stays low and `baud_o` holds its value.
- R5: For a divisor of 2 or more, `tick_o` is never high in two consecutive cycles.
- R6: With a divisor of 1, `tick_o` is high in the cycle after every step.
- R7: With a divisor of 0, the counter holds, `tick_o` stays low and `baud_o` is low.
- R8: For a divisor d of 2 or more and steps on every cycle, `baud_o` is high for floor(d/2) of every d consecutive cycles. For d below 2 it is low.
- R9: With `src_ext_i` high, a step is a rising edge of `ext_baud_i` after a two-stage synchronizer, taken only while `baud_en_i` is high. When the external clock stops, ticks stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| baud_en_i | input | 1 | Step qualifier; the counter advances only while high |
| src_ext_i | input | 1 | 0: step every enabled cycle; 1: step on external clock rising edges |
| ext_baud_i | input | 1 | External baud clock, asynchronous to `clk_i` |
| wr_lo_i | input | 1 | Write strobe for divisor bits 7:0 |
| wr_hi_i | input | 1 | Write strobe for divisor bits 15:8 |
| wdata_i | input | 8 | Divisor byte written by either strobe |
| tick_o | output | 1 | One-cycle pulse at 16x the baud rate |
| baud_o | output | 1 | Square wave at the tick rate |

## Verification
The bound checker checks several rules on every cycle. No tick follows a zero divisor or a cycle without a step. The counter holds when there is no step and no reload. A reload loads the divisor minus one. A divisor of 1 ticks after every step. Ticks never fall in two consecutive cycles for divisors of 2 or more, and `baud_o` stays low below a divisor of 2. Only the bench scenarios can show the spacing between ticks for several divisors, including one set through the high byte. They also show the first-tick latency after a write that lands in the middle of a long count, the duty of `baud_o`, and the timing of ticks paced by a gated enable or by an external clock.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // divisor geometry shared by the generator and its users
  localparam int unsigned DIV_W     = 16;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_BYTES = DIV_W / BYTE_W;

  // step source selection as seen on src_ext_i
  typedef enum logic {
    STEP_SYS = 1'b0,
    STEP_EXT = 1'b1
  } step_src_e;
endpackage

// File: rtl/baud_step_src.sv
// Produces the per-cycle step qualifier for the divisor counter.
module baud_step_src #(
  parameter int unsigned SYNC_STAGES = 2   // at least 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic baud_en_i,
  input  logic src_ext_i,
  input  logic ext_baud_i,
  output logic step_o
);
  import baud_pkg::*;

  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q, sync_n;
  logic         prev_q, prev_n;
  logic         ext_rise;
  step_src_e    src_sel;

  // next state: shift the synchronizer, remember last synchronized level
  always_comb begin
    sync_n = {sync_q[MSB-1:0], ext_baud_i};
    prev_n = sync_q[MSB];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_n;
      prev_q <= prev_n;
    end
  end

  assign ext_rise = sync_q[MSB] & ~prev_q;
  assign src_sel  = step_src_e'(src_ext_i);

  always_comb begin
    unique case (src_sel)
      STEP_EXT: step_o = baud_en_i & ext_rise;
      default:  step_o = baud_en_i;
    endcase
  end
endmodule

// File: rtl/baud_div_regs.sv
// Byte-wide divisor latches and the reload strobe they raise.
module baud_div_regs #(
  parameter int unsigned         DIV_W     = 16,
  parameter int unsigned         BYTE_W    = 8,
  parameter logic [DIV_W-1:0]    RESET_DIV = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_n,
  input  logic [DIV_W/BYTE_W-1:0]    wr_be_i,
  input  logic [BYTE_W-1:0]          wdata_i,
  output logic [DIV_W-1:0]           div_o,
  output logic                       reload_o
);
  localparam int unsigned LANES = DIV_W / BYTE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q, lane_n;

    always_comb begin
      lane_n = lane_q;
      if (wr_be_i[g]) lane_n = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) lane_q <= RESET_DIV[g*BYTE_W +: BYTE_W];
      else        lane_q <= lane_n;
    end

    assign div_o[g*BYTE_W +: BYTE_W] = lane_q;
  end

  // reload one edge after any write so the counter sees the new value
  logic reload_q, reload_n;

  always_comb reload_n = |wr_be_i;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) reload_q <= 1'b0;
    else        reload_q <= reload_n;
  end

  assign reload_o = reload_q;
endmodule

// File: rtl/baud_div_cnt.sv
// Down-counter that wraps at zero, emitting a tick and a half-period wave.
module baud_div_cnt #(
  parameter int unsigned      DIV_W     = 16,
  parameter logic [DIV_W-1:0] RESET_DIV = '0
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             reload_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             baud_o
);
  localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);
  localparam logic [DIV_W-1:0] CNT_RST = (RESET_DIV == '0) ? '0 : RESET_DIV - ONE;

  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             tick_q, tick_n;
  logic             baud_q, baud_n;
  logic [DIV_W-1:0] div_m1, half;
  logic             div_zero, at_end;

  always_comb begin
    div_zero = (div_i == '0);
    div_m1   = div_zero ? '0 : div_i - ONE;
    half     = div_i >> 1;
    at_end   = (cnt_q == '0);
  end

  // next state
  always_comb begin
    cnt_n  = cnt_q;
    tick_n = 1'b0;
    if (reload_i) begin
      cnt_n = div_m1;
    end else if (step_i && !div_zero) begin
      if (at_end) begin
        cnt_n  = div_m1;
        tick_n = 1'b1;
      end else begin
        cnt_n = cnt_q - ONE;
      end
    end
    baud_n = (cnt_n < half);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_RST;
      tick_q <= 1'b0;
      baud_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      tick_q <= tick_n;
      baud_q <= baud_n;
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick_q;
  assign baud_o = baud_q;
endmodule

// File: rtl/baud_divgen.sv
// Top level: reset conditioning, step source, divisor latches, counter.
module baud_divgen #(
  parameter int unsigned                   SYNC_STAGES = 2,
  parameter logic [baud_pkg::DIV_W-1:0]    RESET_DIV   = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       baud_en_i,
  input  logic       src_ext_i,
  input  logic       ext_baud_i,
  input  logic       wr_lo_i,
  input  logic       wr_hi_i,
  input  logic [7:0] wdata_i,
  output logic       tick_o,
  output logic       baud_o
);
  import baud_pkg::*;

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q, rst_pipe_n;
  logic       rst_n_q;

  always_comb rst_pipe_n = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= rst_pipe_n;
  end

  assign rst_n_q = rst_pipe_q[1];

  logic                 step_w;
  logic                 reload_w;
  logic [DIV_W-1:0]     div_w;
  logic [DIV_W-1:0]     cnt_w;
  logic [NUM_BYTES-1:0] wr_be;

  assign wr_be = {wr_hi_i, wr_lo_i};

  baud_step_src #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_src (
    .clk_i     (clk_i),
    .rst_n     (rst_n_q),
    .baud_en_i (baud_en_i),
    .src_ext_i (src_ext_i),
    .ext_baud_i(ext_baud_i),
    .step_o    (step_w)
  );

  baud_div_regs #(
    .DIV_W    (DIV_W),
    .BYTE_W   (BYTE_W),
    .RESET_DIV(RESET_DIV)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_n   (rst_n_q),
    .wr_be_i (wr_be),
    .wdata_i (wdata_i),
    .div_o   (div_w),
    .reload_o(reload_w)
  );

  baud_div_cnt #(
    .DIV_W    (DIV_W),
    .RESET_DIV(RESET_DIV)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_n   (rst_n_q),
    .step_i  (step_w),
    .reload_i(reload_w),
    .div_i   (div_w),
    .cnt_o   (cnt_w),
    .tick_o  (tick_o),
    .baud_o  (baud_o)
  );
endmodule

// File: rtl/baud_divgen_chk.sv
// Cycle rules for the divisor generator, attached by bind.
module baud_divgen_chk #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             step,
  input logic             reload,
  input logic [DIV_W-1:0] div,
  input logic [DIV_W-1:0] cnt,
  input logic             tick_o,
  input logic             baud_o
);
  p_zero_no_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (div == '0) |=> !tick_o);

  p_no_step_no_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !step |=> !tick_o);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!step && !reload) |=> $stable(cnt));

  p_reload_load_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reload && div != '0) |=> (cnt == $past(div) - DIV_W'(1)) && !tick_o);

  p_single_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick_o && div >= DIV_W'(2) && !reload) |=> !tick_o);

  p_div_one_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (div == DIV_W'(1) && step && !reload) |=> tick_o);

  p_baud_low_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (div < DIV_W'(2)) |=> !baud_o);
endmodule

bind baud_divgen baud_divgen_chk #(.DIV_W(baud_pkg::DIV_W)) u_chk (
  .clk_i (clk_i),
  .rst_n (rst_n_q),
  .step  (step_w),
  .reload(reload_w),
  .div   (div_w),
  .cnt   (cnt_w),
  .tick_o(tick_o),
  .baud_o(baud_o)
);

// File: tb/tb_baud_divgen.sv
module tb_baud_divgen;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       baud_en;
  logic       src_ext;
  logic       ext_baud;
  logic       wr_lo, wr_hi;
  logic [7:0] wdata;
  logic       tick_o, baud_o;

  baud_divgen dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .baud_en_i (baud_en),
    .src_ext_i (src_ext),
    .ext_baud_i(ext_baud),
    .wr_lo_i   (wr_lo),
    .wr_hi_i   (wr_hi),
    .wdata_i   (wdata),
    .tick_o    (tick_o),
    .baud_o    (baud_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // scoreboard shared state
  int    exp_q[$];
  string lbl_q[$];
  int    anchor, anchor_seq;        // owned by the driver
  int    mon_cyc, last_tick, seen_seq, ref_c, exp_v, mon_checks, mon_errs;
  string lbl_v;
  int    drv_checks, drv_errs;
  int    en_mode;                   // 0 off, 1 on, 2 toggle each cycle
  bit    ext_run;
  int    ext_ph;
  bit    done;

  task automatic summary(input int extra_err);
    $display("Result: errors=%0d of %0d checks",
             drv_errs + mon_errs + extra_err, drv_checks + mon_checks + extra_err);
  endtask

  // enable pattern generator
  initial begin
    baud_en = 1'b0;
    forever begin
      @(negedge clk);
      case (en_mode)
        0:       baud_en = 1'b0;
        1:       baud_en = 1'b1;
        default: baud_en = ~baud_en;
      endcase
    end
  end

  // external baud clock: toggles every 4 system cycles while running
  initial begin
    ext_baud = 1'b0;
    ext_ph   = 0;
    forever begin
      @(negedge clk);
      if (ext_run) begin
        ext_ph++;
        if (ext_ph == 4) begin
          ext_baud = ~ext_baud;
          ext_ph   = 0;
        end
      end
    end
  end

  // monitor: measure tick spacing, compare with queued expectations
  initial begin
    mon_cyc = 0; last_tick = 0; seen_seq = 0; mon_checks = 0; mon_errs = 0;
    forever begin
      @(posedge clk); #1;
      mon_cyc++;
      if (rst_ni && tick_o) begin
        ref_c    = (anchor_seq != seen_seq) ? anchor : last_tick;
        seen_seq = anchor_seq;
        if (exp_q.size() > 0) begin
          exp_v = exp_q.pop_front();
          lbl_v = lbl_q.pop_front();
          mon_checks++;
          if (mon_cyc - ref_c != exp_v) begin
            mon_errs++;
            $display("FAIL %s: tick spacing actual=%0d expected=%0d", lbl_v, mon_cyc - ref_c, exp_v);
          end
        end
        last_tick = mon_cyc;
      end
    end
  end

  // watchdog
  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary(1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    drv_checks++;
    if (!ok) begin
      drv_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_byte(input bit hi, input logic [7:0] v);
    @(negedge clk);
    wdata = v; wr_lo = !hi; wr_hi = hi;
    @(negedge clk);
    wr_lo = 1'b0; wr_hi = 1'b0;
    anchor = mon_cyc;
    anchor_seq++;
  endtask

  task automatic set_div(input int d);
    wr_byte(1'b1, d[15:8]);
    wr_byte(1'b0, d[7:0]);
  endtask

  task automatic expect_gap(input int n, input string l);
    exp_q.push_back(n);
    lbl_q.push_back(l);
  endtask

  task automatic drain(input string l);
    int k;
    k = 0;
    while (exp_q.size() > 0 && k < 20000) begin
      @(negedge clk);
      k++;
    end
    if (exp_q.size() > 0) begin
      chk(1'b0, l, exp_q.size(), 0);
      exp_q.delete();
      lbl_q.delete();
    end
  endtask

  task automatic wait_tick(input string l);
    int k;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!tick_o && k < 20000);
    if (!tick_o) chk(1'b0, l, 0, 1);
  endtask

  // samples n cycles; counts highs of tick (sel 0) or baud (sel 1)
  task automatic count_hi(input int n, input bit sel, output int c, output int pairs);
    bit prev;
    c = 0; pairs = 0; prev = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if ((sel ? baud_o : tick_o) == 1'b1) begin
        c++;
        if (prev) pairs++;
        prev = 1'b1;
      end else begin
        prev = 1'b0;
      end
    end
  endtask

  initial begin
    int c, p;
    bit b0;
    done = 1'b0;
    drv_checks = 0; drv_errs = 0; anchor = 0; anchor_seq = 0;
    en_mode = 1; ext_run = 1'b0; src_ext = 1'b0;
    wr_lo = 1'b0; wr_hi = 1'b0; wdata = '0;
    rst_ni = 1'b0;
    repeat (5) @(negedge clk);
    chk(tick_o == 1'b0, "R1 tick in reset", int'(tick_o), 0);
    chk(baud_o == 1'b0, "R1 baud in reset", int'(baud_o), 0);
    rst_ni = 1'b1;

    // R1, R7: divisor is zero after reset
    count_hi(40, 1'b0, c, p);
    chk(c == 0, "R1 no tick after reset", c, 0);
    chk(baud_o == 1'b0, "R1 baud after reset", int'(baud_o), 0);

    // R2, R3: low byte divisor
    set_div(5);
    expect_gap(6, "R3 first tick div5");
    expect_gap(5, "R2 period div5");
    expect_gap(5, "R2 period div5");
    expect_gap(5, "R2 period div5");
    drain("R2 div5 drain");

    // R2: high byte in use
    set_div(258);
    expect_gap(259, "R3 first tick div258");
    expect_gap(258, "R2 period div258");
    expect_gap(258, "R2 period div258");
    drain("R2 div258 drain");

    // R3: rewrite in the middle of a long count
    set_div(16'h1008);
    repeat (30) @(negedge clk);
    wr_byte(1'b1, 8'h00);
    expect_gap(9, "R3 reload mid count");
    expect_gap(8, "R2 period div8");
    drain("R3 drain");

    // R6, R8: divisor one
    set_div(1);
    repeat (3) @(negedge clk);
    count_hi(20, 1'b0, c, p);
    chk(c == 20, "R6 tick every cycle", c, 20);
    count_hi(20, 1'b1, c, p);
    chk(c == 0, "R8 baud low div1", c, 0);

    // R5: divisor two
    set_div(2);
    repeat (4) @(negedge clk);
    count_hi(40, 1'b0, c, p);
    chk(c == 20, "R5 tick count div2", c, 20);
    chk(p == 0, "R5 no back-to-back ticks", p, 0);

    // R8: duty
    set_div(10);
    wait_tick("R8 div10 tick");
    count_hi(10, 1'b1, c, p);
    chk(c == 5, "R8 baud duty div10", c, 5);
    set_div(7);
    wait_tick("R8 div7 tick");
    count_hi(7, 1'b1, c, p);
    chk(c == 3, "R8 baud duty div7", c, 3);

    // R4: enable low freezes
    set_div(4);
    en_mode = 0;
    repeat (3) @(negedge clk);
    b0 = baud_o;
    count_hi(50, 1'b0, c, p);
    chk(c == 0, "R4 no tick with enable low", c, 0);
    count_hi(50, 1'b1, c, p);
    chk(c == (b0 ? 50 : 0), "R4 baud held with enable low", c, b0 ? 50 : 0);

    // R4: gated enable halves the step rate
    en_mode = 2;
    set_div(3);
    wait_tick("R4 gated tick");
    expect_gap(6, "R4 gated period");
    expect_gap(6, "R4 gated period");
    expect_gap(6, "R4 gated period");
    drain("R4 gated drain");
    en_mode = 1;

    // R7: return to zero stops everything
    set_div(9);
    wait_tick("R7 div9 tick");
    set_div(0);
    repeat (3) @(negedge clk);
    count_hi(60, 1'b0, c, p);
    chk(c == 0, "R7 no tick div0", c, 0);
    count_hi(20, 1'b1, c, p);
    chk(c == 0, "R7 baud low div0", c, 0);

    // R9: external clock pacing
    src_ext = 1'b1;
    ext_run = 1'b1;
    set_div(2);
    wait_tick("R9 ext tick");
    expect_gap(16, "R9 ext period");
    expect_gap(16, "R9 ext period");
    expect_gap(16, "R9 ext period");
    drain("R9 ext drain");
    ext_run = 1'b0;
    repeat (20) @(negedge clk);
    count_hi(40, 1'b0, c, p);
    chk(c == 0, "R9 ext stopped", c, 0);

    done = 1'b1;
    summary(0);
    $finish;
  end
endmodule